// File: doc/BRIEF.md
# Multi-Channel DMA Control Register Bank

This block holds the software-visible control and status state of a multi-channel DMA engine. It sits behind a simple 32-bit register bus. A small set of global registers is decoded directly: an identification word, a global control word, a channel selector, a port selector and a per-channel interrupt enable bitmap. The remaining registers belong to one channel or one port and are reached through a selection window. Software first writes the channel number into the channel selector, then reads or writes the control, polling, descriptor ring and interrupt registers of that channel. Port configuration works the same way through the port selector.

Each channel keeps four kinds of state: an on/off bit, a transmit-direction bit and a two-bit weight; a descriptor ring base and entry count; a polling setup; and six interrupt status bits with matching enables. A per-channel event input sets the descriptor-complete status bit. A channel reset request clears the channel and reports itself busy for a fixed number of cycles. The single interrupt output is raised while any globally enabled channel has an enabled status bit pending. Reads are combinational from the address and have no side effects.

Top module: `dmac_regbank`

## Requirements
- R1: After reset, or after a write of 1 to bit 0 of the global control register (0x10), every register reads 0, except the identification register. The global control register itself always reads 0.
- R2: The identification register (0x08) reads the revision in bits 4:0, the port count in bits 19:16 and the channel count in bits 31:20. With default parameters this is 0x0144_0003.
- R3: Offsets 0x14, 0x1C, 0x20, 0x24, 0x28 and 0x2C access only the channel whose number was last written to the channel selector at 0x18. The selector reads back the value written, in bits 7:0.
- R4: While the channel selector holds 20 or more, writes to the channel offsets change no channel, and reads of those offsets return 0.
- R5: Channel control (0x1C) keeps the on bit at bit 0, the transmit bit at bit 8 and the weight at bits 17:16. All other bits read 0 when no reset is running.
- R6: Writing 1 to channel control bit 1 clears that channel's on, transmit, weight and status bits. Bit 1 then reads 1 for exactly 4 cycles after the write edge and reads 0 afterwards. Control writes and events that arrive while the reset is running are ignored.
- R7: Channel interrupt status (0x28) holds bits 6:1. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and bits 0 and 31:7 read 0.
- R8: A high level on ch_evt[n] sets status bit 3 (descriptor complete) of channel n. This happens whatever channel is selected, and the set wins over a clear in the same cycle.
- R9: Channel interrupt enable (0x2C) stores bits 6:1. All other bits read 0.
- R10: irq is high exactly when some channel n has bit n of the global enable bitmap set and a status bit that is also set in its own enable register. irq changes only after a bus write or an event.
- R11: The global enable bitmap (0xF4) stores one bit per channel in bits 19:0. The upper bits read 0.
- R12: Channel poll (0x14) keeps bit 31 (poll enable) and bit 6 (divide by 4). Descriptor base (0x20) keeps all 32 bits. Descriptor count (0x24) keeps bits 15:0.
- R13: Port control (0x44) acts on the port held in the port selector (0x40) and keeps only bits 11:8, 6, 5:4 and 3:2 (mask 0xF7C). A selector of 4 or more ignores writes and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ch_evt | input | 20 | Per-channel descriptor-complete event |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong selector decode shows up on the next read: either a write lands in a neighbouring channel, or a channel read returns the wrong channel's data. A reset counter of the wrong length shows up as bit 1 of channel control falling one cycle early or late against a cycle-exact poll. Status corruption shows up on irq in the cycle after the event or write that caused it. That includes a lost set-over-clear priority or a global enable bit that is off by one channel.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam logic [7:0] OFS_ID    = 8'h08;
  localparam logic [7:0] OFS_GCTL  = 8'h10;
  localparam logic [7:0] OFS_POLL  = 8'h14;
  localparam logic [7:0] OFS_CSEL  = 8'h18;
  localparam logic [7:0] OFS_CCTL  = 8'h1C;
  localparam logic [7:0] OFS_DBASE = 8'h20;
  localparam logic [7:0] OFS_DCNT  = 8'h24;
  localparam logic [7:0] OFS_CSTAT = 8'h28;
  localparam logic [7:0] OFS_CIEN  = 8'h2C;
  localparam logic [7:0] OFS_PSEL  = 8'h40;
  localparam logic [7:0] OFS_PCTL  = 8'h44;
  localparam logic [7:0] OFS_GIEN  = 8'hF4;

  localparam int CC_ON   = 0;
  localparam int CC_RST  = 1;
  localparam int CC_DIR  = 8;
  localparam int CC_WLO  = 16;
  localparam int PL_EN   = 31;
  localparam int PL_DIV4 = 6;
  localparam int EV_DESC = 3;   // descriptor-complete status bit

  localparam logic [31:0] PCTL_MASK = 32'h0000_0F7C;

  typedef struct packed {
    logic       on;
    logic       dir;
    logic [1:0] weight;
  } cctl_t;

  function automatic logic [31:0] id_word(input int nch, input int nport, input logic [4:0] rev);
    id_word = {12'(nch), 4'(nport), 11'd0, rev};
  endfunction

  // status update: write-one-to-clear on bits 6:1, event set wins
  function automatic logic [5:0] stat_next(input logic [5:0] cur, input logic do_clr,
                                           input logic [5:0] clr, input logic set_desc);
    logic [5:0] r;
    r = do_clr ? (cur & ~clr) : cur;
    if (set_desc) r[EV_DESC-1] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        wr_cctl,
  input  logic        wr_poll,
  input  logic        wr_base,
  input  logic        wr_cnt,
  input  logic        wr_stat,
  input  logic        wr_ien,
  input  logic [31:0] wdata,
  input  logic        evt,
  output logic [31:0] cctl_rd,
  output logic [31:0] poll_rd,
  output logic [31:0] base_rd,
  output logic [31:0] cnt_rd,
  output logic [31:0] stat_rd,
  output logic [31:0] ien_rd,
  output logic        pend
);
  localparam int RW = $clog2(RST_CYC + 1);

  cctl_t            ctl_q;
  logic [RW-1:0]    rcnt_q;
  logic [1:0]       poll_q;
  logic [31:0]      base_q;
  logic [CNT_W-1:0] dcnt_q;
  logic [5:0]       stat_q, ien_q;
  logic             busy, rst_req, evt_take;

  assign busy     = (rcnt_q != '0);
  assign rst_req  = wr_cctl && wdata[CC_RST] && !busy;
  assign evt_take = evt && !busy && !rst_req;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      ctl_q  <= '0;
      rcnt_q <= '0;
      poll_q <= '0;
      base_q <= '0;
      dcnt_q <= '0;
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      if (rst_req) begin
        ctl_q  <= '0;
        rcnt_q <= RW'(RST_CYC);
      end else if (busy) begin
        rcnt_q <= rcnt_q - 1'b1;
      end else if (wr_cctl) begin
        ctl_q <= '{on: wdata[CC_ON], dir: wdata[CC_DIR], weight: wdata[CC_WLO+1:CC_WLO]};
      end
      if (wr_poll) poll_q <= {wdata[PL_EN], wdata[PL_DIV4]};
      if (wr_base) base_q <= wdata;
      if (wr_cnt)  dcnt_q <= wdata[CNT_W-1:0];
      if (wr_ien)  ien_q  <= wdata[6:1];
      if (rst_req || busy) stat_q <= '0;
      else stat_q <= stat_next(stat_q, wr_stat, wdata[6:1], evt_take);
    end
  end

  always_comb begin
    cctl_rd = '0;
    cctl_rd[CC_ON]             = ctl_q.on;
    cctl_rd[CC_RST]            = busy;
    cctl_rd[CC_DIR]            = ctl_q.dir;
    cctl_rd[CC_WLO+1:CC_WLO]   = ctl_q.weight;
    poll_rd = '0;
    poll_rd[PL_EN]             = poll_q[1];
    poll_rd[PL_DIV4]           = poll_q[0];
  end
  assign base_rd = base_q;
  assign cnt_rd  = 32'(dcnt_q);
  assign stat_rd = {25'd0, stat_q, 1'b0};
  assign ien_rd  = {25'd0, ien_q, 1'b0};
  assign pend    = |(stat_q & ien_q);

  // R6: a reset request clears the channel and shows busy next cycle
  a_r6_rst_clears: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    rst_req |=> (busy && !ctl_q.on && !ctl_q.dir && stat_q == '0));
  // R6: the last busy cycle is followed by idle
  a_r6_rst_ends: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (rcnt_q == RW'(1)) |=> !busy);
  // R8: an accepted event sets descriptor-complete status
  a_r8_evt_sets: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    evt_take |=> stat_q[EV_DESC-1]);
  // R7: write-one-to-clear removes the addressed bits when nothing sets them
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (wr_stat && !evt && !busy) |=> ((stat_q & $past(wdata[6:1])) == '0));
endmodule

// File: rtl/dmac_ports.sv
module dmac_ports
  import dmac_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        wr_psel,
  input  logic        wr_pctl,
  input  logic [31:0] wdata,
  output logic [31:0] psel_rd,
  output logic [31:0] pctl_rd
);
  logic [7:0]  psel_q;
  logic [31:0] pctl_q [NPORT];
  logic [NPORT-1:0] p_hit;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) psel_q <= '0;
    else if (wr_psel)       psel_q <= wdata[7:0];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign p_hit[p] = (psel_q == 8'(p));
    always_ff @(posedge clk) begin
      if (!rst_n || soft_rst)     pctl_q[p] <= '0;
      else if (wr_pctl && p_hit[p]) pctl_q[p] <= wdata & PCTL_MASK;
    end
  end

  always_comb begin
    pctl_rd = '0;
    for (int p = 0; p < NPORT; p++)
      if (p_hit[p]) pctl_rd = pctl_q[p];
  end
  assign psel_rd = 32'(psel_q);

  // R13: a selector value decodes to at most one port
  a_r13_port_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(p_hit));
endmodule

// File: rtl/dmac_irq.sv
module dmac_irq #(
  parameter int NCH = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           wr_gien,
  input  logic [31:0]    wdata,
  input  logic [NCH-1:0] pend,
  output logic [31:0]    gien_rd,
  output logic           irq
);
  logic [NCH-1:0] gien_q;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) gien_q <= '0;
    else if (wr_gien)       gien_q <= wdata[NCH-1:0];
  end

  assign gien_rd = 32'(gien_q);
  assign irq     = |(gien_q & pend);
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
  import dmac_pkg::*;
#(
  parameter int         NCH     = 20,
  parameter int         NPORT   = 4,
  parameter int         CNT_W   = 16,
  parameter int         RST_CYC = 4,
  parameter logic [4:0] REV     = 5'h03
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] ch_evt,
  output logic           irq
);
  localparam logic [31:0] ID_VAL = id_word(NCH, NPORT, REV);

  logic [7:0]     csel_q;
  logic           sel_ok, soft_rst, ch_window;
  logic [NCH-1:0] ch_hit, pend;
  logic [31:0]    cctl_rd [NCH];
  logic [31:0]    poll_rd [NCH];
  logic [31:0]    base_rd [NCH];
  logic [31:0]    cnt_rd  [NCH];
  logic [31:0]    stat_rd [NCH];
  logic [31:0]    ien_rd  [NCH];
  logic [31:0]    psel_rd, pctl_rd, gien_rd, ch_val;

  assign soft_rst  = bus_wr && (bus_addr == OFS_GCTL) && bus_wdata[0];
  assign sel_ok    = (csel_q < 8'(NCH));
  assign ch_window = (bus_addr == OFS_POLL) || (bus_addr == OFS_CCTL) ||
                     (bus_addr == OFS_DBASE) || (bus_addr == OFS_DCNT) ||
                     (bus_addr == OFS_CSTAT) || (bus_addr == OFS_CIEN);

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst)                      csel_q <= '0;
    else if (bus_wr && bus_addr == OFS_CSEL)     csel_q <= bus_wdata[7:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic w;
    assign ch_hit[c] = sel_ok && (csel_q == 8'(c));
    assign w         = bus_wr && ch_hit[c];
    dmac_chan #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chan (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_cctl(w && bus_addr == OFS_CCTL), .wr_poll(w && bus_addr == OFS_POLL),
      .wr_base(w && bus_addr == OFS_DBASE), .wr_cnt(w && bus_addr == OFS_DCNT),
      .wr_stat(w && bus_addr == OFS_CSTAT), .wr_ien(w && bus_addr == OFS_CIEN),
      .wdata(bus_wdata), .evt(ch_evt[c]),
      .cctl_rd(cctl_rd[c]), .poll_rd(poll_rd[c]), .base_rd(base_rd[c]),
      .cnt_rd(cnt_rd[c]), .stat_rd(stat_rd[c]), .ien_rd(ien_rd[c]), .pend(pend[c])
    );
  end

  dmac_ports #(.NPORT(NPORT)) u_ports (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_psel(bus_wr && bus_addr == OFS_PSEL), .wr_pctl(bus_wr && bus_addr == OFS_PCTL),
    .wdata(bus_wdata), .psel_rd(psel_rd), .pctl_rd(pctl_rd)
  );

  dmac_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_gien(bus_wr && bus_addr == OFS_GIEN), .wdata(bus_wdata),
    .pend(pend), .gien_rd(gien_rd), .irq(irq)
  );

  always_comb begin
    ch_val = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_hit[c]) begin
        case (bus_addr)
          OFS_POLL:  ch_val = poll_rd[c];
          OFS_CCTL:  ch_val = cctl_rd[c];
          OFS_DBASE: ch_val = base_rd[c];
          OFS_DCNT:  ch_val = cnt_rd[c];
          OFS_CSTAT: ch_val = stat_rd[c];
          OFS_CIEN:  ch_val = ien_rd[c];
          default:   ch_val = '0;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_ID:   bus_rdata = ID_VAL;
      OFS_CSEL: bus_rdata = 32'(csel_q);
      OFS_PSEL: bus_rdata = psel_rd;
      OFS_PCTL: bus_rdata = pctl_rd;
      OFS_GIEN: bus_rdata = gien_rd;
      default:  bus_rdata = ch_window ? ch_val : '0;
    endcase
  end

  // R3: the selector picks at most one channel
  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_hit));
  // R4: an out-of-range selector makes channel reads return zero
  a_r4_bad_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && ch_window) |-> (bus_rdata == '0));
  // R10: without a write or an event the interrupt line holds
  a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bus_wr) && $past(ch_evt) == '0) |-> $stable(irq));
endmodule

// File: tb/tb_dmac_regbank.sv
module tb_dmac_regbank;
  localparam int NCH = 20;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, irq;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] ch_evt = '0;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  dmac_regbank dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_evt(ch_evt), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v); chk(tag, v, exp);
  endtask

  task automatic t_reset_id();
    rdchk("R2 id", 8'h08, 32'h0144_0003);
    rdchk("R1 gien reset", 8'hF4, 0);
    rdchk("R1 ctl reset", 8'h1C, 0);
    rdchk("R1 gctl reads 0", 8'h10, 0);
    chk("R1 irq reset", 32'(irq), 0);
  endtask

  task automatic t_fields();
    wr(8'h18, 2);
    rdchk("R3 csel readback", 8'h18, 2);
    wr(8'h1C, 32'hFFFF_FFFD);
    rdchk("R5 ctl mask", 8'h1C, 32'h0003_0101);
    wr(8'h14, 32'hFFFF_FFFF);
    rdchk("R12 poll mask", 8'h14, 32'h8000_0040);
    wr(8'h20, 32'hDEAD_BEE0);
    rdchk("R12 base", 8'h20, 32'hDEAD_BEE0);
    wr(8'h24, 32'h0001_2345);
    rdchk("R12 count", 8'h24, 32'h0000_2345);
    wr(8'h2C, 32'hFFFF_FFFF);
    rdchk("R9 ien mask", 8'h2C, 32'h0000_007E);
    wr(8'h18, 1);
    wr(8'h20, 32'h1111_0000);
    rdchk("R3 ch1 base", 8'h20, 32'h1111_0000);
    rdchk("R3 ch1 ctl untouched", 8'h1C, 0);
    wr(8'h18, 2);
    rdchk("R3 ch2 base kept", 8'h20, 32'hDEAD_BEE0);
  endtask

  task automatic t_bad_sel();
    wr(8'h18, 0); wr(8'h1C, 32'h0001_0000);
    wr(8'h18, 20); wr(8'h1C, 32'h0000_0101);
    rdchk("R4 csel 20 readback", 8'h18, 20);
    rdchk("R4 read zero", 8'h1C, 0);
    wr(8'h18, 0);
    rdchk("R4 ch0 unchanged", 8'h1C, 32'h0001_0000);
  endtask

  task automatic t_status_irq();
    wr(8'h18, 5); wr(8'h2C, 32'h08); wr(8'hF4, 32'h0000_0020);
    rdchk("R11 gien", 8'hF4, 32'h0000_0020);
    chk("R10 no irq", 32'(irq), 0);
    @(negedge clk); ch_evt[5] = 1'b1; @(negedge clk); ch_evt[5] = 1'b0;
    rdchk("R8 evt sets bit3", 8'h28, 32'h08);
    chk("R10 irq set", 32'(irq), 1);
    wr(8'hF4, 32'h0000_0010);
    chk("R10 other global bit", 32'(irq), 0);
    wr(8'hF4, 32'hFFFF_FFFF);
    rdchk("R11 width", 8'hF4, 32'h000F_FFFF);
    chk("R10 irq back", 32'(irq), 1);
    wr(8'h28, 32'h0000_0000);
    rdchk("R7 write 0 keeps", 8'h28, 32'h08);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h7E; ch_evt[5] = 1'b1;
    @(negedge clk); bus_wr = 1'b0; ch_evt[5] = 1'b0;
    rdchk("R8 set beats clear", 8'h28, 32'h08);
    wr(8'h28, 32'hFFFF_FFFF);
    rdchk("R7 w1c", 8'h28, 0);
    chk("R10 irq cleared", 32'(irq), 0);
    wr(8'h2C, 0);
    @(negedge clk); ch_evt[5] = 1'b1; @(negedge clk); ch_evt[5] = 1'b0;
    chk("R10 masked by channel enable", 32'(irq), 0);
    wr(8'h18, 6);
    @(negedge clk); ch_evt[5] = 1'b1; @(negedge clk); ch_evt[5] = 1'b0;
    wr(8'h18, 5);
    rdchk("R8 evt when unselected", 8'h28, 32'h08);
  endtask

  task automatic t_chan_reset();
    wr(8'h18, 5);
    wr(8'h1C, 32'h0003_0101);
    wr(8'h1C, 32'h0000_0002);
    rdchk("R6 busy t1", 8'h1C, 32'h2);
    rdchk("R6 status cleared", 8'h28, 0);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk); ch_evt[5] = 1'b1;
      rdchk($sformatf("R6 busy t%0d", k), 8'h1C, 32'h2);
    end
    ch_evt[5] = 1'b0;
    @(negedge clk);
    rdchk("R6 reset done", 8'h1C, 0);
    rdchk("R6 events ignored while busy", 8'h28, 0);
  endtask

  task automatic t_ports_global();
    wr(8'h40, 1); wr(8'h44, 32'hFFFF_FFFF);
    rdchk("R13 pctl mask", 8'h44, 32'h0000_0F7C);
    wr(8'h40, 0);
    rdchk("R13 port0 separate", 8'h44, 0);
    wr(8'h40, 4); wr(8'h44, 32'hFFFF_FFFF);
    rdchk("R13 bad port read 0", 8'h44, 0);
    wr(8'h40, 1);
    rdchk("R13 port1 kept", 8'h44, 32'h0000_0F7C);
    wr(8'h10, 1);
    rdchk("R1 soft reset pctl", 8'h44, 0);
    rdchk("R1 soft reset psel", 8'h40, 0);
    rdchk("R1 soft reset gien", 8'hF4, 0);
    wr(8'h18, 2);
    rdchk("R1 soft reset base", 8'h20, 0);
    rdchk("R2 id after soft reset", 8'h08, 32'h0144_0003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_id();
    t_fields();
    t_bad_sel();
    t_status_irq();
    t_chan_reset();
    t_ports_global();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule